// File: doc/BRIEF.md
# Column-Stationary Matrix Multiply Engine

This block forms the integer product C = X·Y of two square N×N matrices. It holds a group of ACC columns of Y in a local buffer and runs every row of X past that group before the next group is brought in. Two accumulator pipes share the buffer. Each pipe has ACC accumulators working side by side, one for each resident column. Rows of X alternate between the pipes: even rows go to pipe 0 and odd rows to pipe 1. While one pipe is summing a row, the other can hand out the finished sums of the previous row.

A user first writes the resident columns one element at a time through the load port. The user then raises `cols_loaded`, streams all N rows of X in row-major order, and collects N·ACC tagged results. When the last result of the group has been taken, `grp_done` pulses for one cycle. The user then lowers `cols_loaded`, loads the next column group and raises `cols_loaded` again. Groups are counted modulo N/ACC, and the group count sets the column tags. The schedule is fixed: element positions come from internal counters, and nothing is checked for hazards at run time.

Both streams follow valid/ready rules. A transfer happens on a rising clock edge where valid and ready are both high. Once `res_valid` is raised, it and the result fields hold steady until `res_ready` accepts them. `x_ready` is low whenever the pipe that is due to take the next row still holds sums that have not been handed out. Back-pressure on the result port therefore reaches the input stream without any sum being dropped or repeated.

Top module: `cs_matmul`

## Requirements
- R1: After reset, `x_ready`, `res_valid` and `grp_done` are low, and the block waits in the load phase.
- R2: A write with `ld_we` high stores `ld_data` as element Y[ld_k][g·ACC+ld_j] of the resident group. Writes are accepted in every phase except computation. A write made while a group is being computed leaves the results unchanged.
- R3: `x_ready` stays low until `cols_loaded` has been seen high in the load phase, whatever `x_valid` does.
- R4: For X streamed row by row (element x[i][k] is the k-th transfer of row i), every result equals the sum over k of x[i][k]·y[k][j]. The inputs are DW-bit two's complement, and the result is exact at AW = 2·DW+clog2(N)+1 bits.
- R5: Results come out in row order, and within a row in ascending column order. `res_row` carries i. Each group yields N·ACC results, so a whole matrix yields N·N.
- R6: With `x_valid` and `res_ready` held high and ACC ≤ N, `x_ready` never drops from the first to the last element of a group (one element per cycle).
- R7: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data`, `res_row` and `res_col` hold their values on the next cycle.
- R8: `grp_done` is high for exactly the one cycle after the last result of a group is transferred, and is low at all other times.
- R9: `res_col` equals g·ACC+j, where g counts completed groups modulo N/ACC, starting from 0 after reset.
- R10: After a group ends, `x_ready` stays low until `cols_loaded` has gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cols_loaded | input | 1 | Level: the resident column group is complete |
| ld_we | input | 1 | Column element write strobe |
| ld_k | input | KW | Row index k of the written element |
| ld_j | input | JW | Local column index j within the group |
| ld_data | input | DW | Element value, two's complement |
| x_valid | input | 1 | X element offered |
| x_ready | output | 1 | X element accepted on this edge if valid |
| x_data | input | DW | X element, row-major order |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result taken on this edge if valid |
| res_data | output | AW | Dot product, two's complement |
| res_row | output | KW | Row tag i |
| res_col | output | KW | Column tag g·ACC+j |
| grp_done | output | 1 | One-cycle pulse after the last result of a group |

## Verification
The two functions that overlap are accumulation of a new row into one pipe and hand-out of finished sums from the other pipe in the same cycle. A stall on one must never corrupt or repeat the other. The bench provokes this with N=8 and ACC=4 in three ways: random gaps on both streams, a stall-free group where the overlap happens on every row, and a group with result ready held low most of the time, so that the input stalls behind a pipe that is still full. Each case is judged by comparing every tagged result, in its expected order, against a product computed in the bench. Held results are checked for stability, and in the stall-free group the bench checks that the input never waited.

// File: rtl/cs_mm_pkg.sv
package cs_mm_pkg;
  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_RUN  = 2'd1,
    PH_HOLD = 2'd2
  } phase_e;
endpackage

// File: rtl/cs_mm_store.sv
module cs_mm_store #(
  parameter int N   = 48,
  parameter int ACC = 48,
  parameter int DW  = 8,
  localparam int KW = $clog2(N),
  localparam int JW = $clog2(ACC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [KW-1:0]     wr_k,
  input  logic [JW-1:0]     wr_j,
  input  logic [DW-1:0]     wr_data,
  input  logic [KW-1:0]     rd_k,
  output logic [ACC*DW-1:0] rd_row
);
  logic [DW-1:0] mem [N][ACC];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_k][wr_j] <= wr_data;
  end

  for (genvar j = 0; j < ACC; j++) begin : g_rd
    assign rd_row[j*DW +: DW] = mem[rd_k][j];
  end

  // R2: writes that reach the buffer address a real element
  p_wr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_k) < N && int'(wr_j) < ACC));
endmodule

// File: rtl/cs_mm_pipe.sv
module cs_mm_pipe #(
  parameter int ACC = 48,
  parameter int DW  = 8,
  parameter int AW  = 23,
  localparam int JW = $clog2(ACC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic              last,
  input  logic [DW-1:0]     x,
  input  logic [ACC*DW-1:0] yrow,
  input  logic              pop,
  output logic              full,
  output logic [JW-1:0]     idx,
  output logic [AW-1:0]     sum
);
  logic [ACC*AW-1:0] acc_flat;

  for (genvar j = 0; j < ACC; j++) begin : g_acc
    logic signed [DW-1:0]   yj;
    logic signed [2*DW-1:0] prod;
    logic [AW-1:0]          a_q;
    assign yj   = yrow[j*DW +: DW];
    assign prod = $signed(x) * yj;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) a_q <= '0;
      else if (take)
        a_q <= (first ? '0 : a_q) + {{(AW-2*DW){prod[2*DW-1]}}, prod};
    end
    assign acc_flat[j*AW +: AW] = a_q;
  end

  always_comb begin
    sum = '0;
    for (int j = 0; j < ACC; j++)
      if (idx == JW'(j)) sum = acc_flat[j*AW +: AW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      idx  <= '0;
    end else if (take && last) begin
      full <= 1'b1;
      idx  <= '0;
    end else if (pop) begin
      if (idx == JW'(ACC-1)) begin
        full <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R7: a pipe holding finished sums never takes new elements
  p_no_take_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !take);
  // R7: an offered sum does not change until it is taken
  p_sum_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> $stable(sum));
endmodule

// File: rtl/cs_mm_seq.sv
module cs_mm_seq
  import cs_mm_pkg::*;
#(
  parameter int N   = 48,
  parameter int ACC = 48,
  localparam int KW = $clog2(N),
  localparam int NG = N / ACC,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cols_loaded,
  input  logic          x_valid,
  output logic          x_ready,
  input  logic          res_ready,
  input  logic [1:0]    full,
  input  logic          out_last,
  output logic [1:0]    take,
  output logic          first,
  output logic          last,
  output logic [KW-1:0] rd_k,
  output logic          res_valid,
  output logic [1:0]    pop,
  output logic          out_ptr,
  output logic [KW-1:0] out_row,
  output logic [GW-1:0] grp,
  output logic          grp_done,
  output logic          wr_ok
);
  phase_e        phase;
  logic [KW-1:0] in_k, in_row;
  logic          in_done, tgt, x_fire, res_fire, row_end, grp_end;

  always_comb begin
    tgt       = in_row[0];
    x_ready   = (phase == PH_RUN) && !in_done && !full[tgt];
    x_fire    = x_valid && x_ready;
    take      = x_fire ? (tgt ? 2'b10 : 2'b01) : 2'b00;
    first     = (in_k == '0);
    last      = (in_k == KW'(N-1));
    rd_k      = in_k;
    res_valid = full[out_ptr];
    res_fire  = res_valid && res_ready;
    pop       = res_fire ? (out_ptr ? 2'b10 : 2'b01) : 2'b00;
    row_end   = res_fire && out_last;
    grp_end   = row_end && (out_row == KW'(N-1));
    wr_ok     = (phase != PH_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_LOAD;
      in_k     <= '0;
      in_row   <= '0;
      in_done  <= 1'b0;
      out_ptr  <= 1'b0;
      out_row  <= '0;
      grp      <= '0;
      grp_done <= 1'b0;
    end else begin
      grp_done <= grp_end;
      if (x_fire) begin
        if (last) begin
          in_k <= '0;
          if (in_row == KW'(N-1)) begin
            in_row  <= '0;
            in_done <= 1'b1;
          end else begin
            in_row <= in_row + 1'b1;
          end
        end else begin
          in_k <= in_k + 1'b1;
        end
      end
      if (row_end) begin
        out_ptr <= ~out_ptr;
        out_row <= (out_row == KW'(N-1)) ? '0 : out_row + 1'b1;
      end
      case (phase)
        PH_LOAD: if (cols_loaded) begin
          phase   <= PH_RUN;
          in_done <= 1'b0;
        end
        PH_RUN: if (grp_end) begin
          phase <= PH_HOLD;
          grp   <= (int'(grp) == NG-1) ? '0 : grp + 1'b1;
        end
        PH_HOLD: if (!cols_loaded) phase <= PH_LOAD;
        default: phase <= PH_LOAD;
      endcase
    end
  end

  // R10: computing starts only from a load phase that saw the flag high
  p_run_after_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && $past(phase) == PH_LOAD) |-> $past(cols_loaded));
  // R8: group completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> !grp_done);
  // R7: an offered result is not withdrawn
  p_hold_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid);
  // R5: rows leave in ascending order
  p_row_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_end && out_row != KW'(N-1)) |=> (out_row == $past(out_row) + 1'b1));
endmodule

// File: rtl/cs_matmul.sv
module cs_matmul #(
  parameter int N   = 48,
  parameter int ACC = 48,
  parameter int DW  = 8,
  localparam int KW = $clog2(N),
  localparam int JW = $clog2(ACC),
  localparam int AW = 2*DW + $clog2(N) + 1,
  localparam int NG = N / ACC,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cols_loaded,
  input  logic          ld_we,
  input  logic [KW-1:0] ld_k,
  input  logic [JW-1:0] ld_j,
  input  logic [DW-1:0] ld_data,
  input  logic          x_valid,
  output logic          x_ready,
  input  logic [DW-1:0] x_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [AW-1:0] res_data,
  output logic [KW-1:0] res_row,
  output logic [KW-1:0] res_col,
  output logic          grp_done
);
  logic [1:0]        take, pop, full;
  logic              first, last, out_ptr, out_last, wr_ok;
  logic [KW-1:0]     rd_k;
  logic [GW-1:0]     grp;
  logic [ACC*DW-1:0] rd_row;
  logic [JW-1:0]     pidx [2];
  logic [AW-1:0]     psum [2];

  cs_mm_seq #(.N(N), .ACC(ACC)) u_seq (
    .clk(clk), .rst_n(rst_n), .cols_loaded(cols_loaded),
    .x_valid(x_valid), .x_ready(x_ready), .res_ready(res_ready),
    .full(full), .out_last(out_last), .take(take), .first(first),
    .last(last), .rd_k(rd_k), .res_valid(res_valid), .pop(pop),
    .out_ptr(out_ptr), .out_row(res_row), .grp(grp),
    .grp_done(grp_done), .wr_ok(wr_ok)
  );

  cs_mm_store #(.N(N), .ACC(ACC), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(ld_we && wr_ok), .wr_k(ld_k),
    .wr_j(ld_j), .wr_data(ld_data), .rd_k(rd_k), .rd_row(rd_row)
  );

  for (genvar p = 0; p < 2; p++) begin : g_pipe
    cs_mm_pipe #(.ACC(ACC), .DW(DW), .AW(AW)) u_pipe (
      .clk(clk), .rst_n(rst_n), .take(take[p]), .first(first),
      .last(last), .x(x_data), .yrow(rd_row), .pop(pop[p]),
      .full(full[p]), .idx(pidx[p]), .sum(psum[p])
    );
  end

  always_comb begin
    out_last = (pidx[out_ptr] == JW'(ACC-1));
    res_data = psum[out_ptr];
    res_col  = KW'(int'(grp) * ACC + int'(pidx[out_ptr]));
  end
endmodule

// File: tb/cs_matmul_bench.sv
`timescale 1ns/1ps
module cs_matmul_bench;
  localparam int N = 8, ACC = 4, DW = 8;
  localparam int KW = 3, JW = 2, AW = 2*DW + 3 + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cols_loaded, ld_we, x_valid, x_ready, res_valid, res_ready, grp_done;
  logic [KW-1:0] ld_k, res_row, res_col;
  logic [JW-1:0] ld_j;
  logic [DW-1:0] ld_data, x_data;
  logic [AW-1:0] res_data;

  cs_matmul #(.N(N), .ACC(ACC), .DW(DW)) u_cs_matmul (.*);

  int total = 0, bad = 0, stalls = 0, mat_cnt = 0;
  int X [N][N];
  int Y [N][N];

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_c(input int i, input int j);
    int s = 0;
    for (int k = 0; k < N; k++) s += X[i][k] * Y[k][j];
    return s;
  endfunction

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  task automatic load_group(input int g);
    for (int k = 0; k < N; k++)
      for (int j = 0; j < ACC; j++) begin
        @(posedge clk); #1;
        ld_we = 1'b1; ld_k = KW'(k); ld_j = JW'(j); ld_data = DW'(Y[k][g*ACC+j]);
      end
    @(posedge clk); #1;
    ld_we = 1'b0;
  endtask

  task automatic drive_x(input int vprob, input bit garbage);
    int idx = 0;
    bit fire;
    stalls = 0;
    x_valid = 1'b0;
    while (idx < N*N) begin
      @(negedge clk);
      fire = x_valid && x_ready;
      if (x_valid && !x_ready && idx > 0) stalls++;
      @(posedge clk); #1;
      if (fire) idx++;
      if (!x_valid || fire) begin
        if (idx < N*N && $urandom_range(99) < vprob) begin
          x_valid = 1'b1;
          x_data  = DW'(X[idx/N][idx%N]);
        end else begin
          x_valid = 1'b0;
        end
      end
      if (garbage) begin
        ld_we   = (idx > 10 && idx < 30);
        ld_k    = KW'($urandom_range(N-1));
        ld_j    = JW'($urandom_range(ACC-1));
        ld_data = DW'($urandom);
      end
    end
    x_valid = 1'b0;
    ld_we   = 1'b0;
  endtask

  task automatic sink(input int g, input int rprob, input string dtag);
    int cnt = 0, r = 0, j = 0;
    bit held = 1'b0;
    logic [AW-1:0] hd;
    logic [KW-1:0] hc;
    res_ready = 1'b0;
    while (cnt < N*ACC) begin
      @(negedge clk);
      if (grp_done) chk(1'b0, "R8 early pulse", 1, 0);
      if (held) begin
        chk(res_valid && res_data == hd && res_col == hc, "R7 held result",
            int'($signed(res_data)), int'($signed(hd)));
        held = 1'b0;
      end
      if (res_valid && res_ready) begin
        chk(int'(res_row) == r, "R5 row tag", int'(res_row), r);
        chk(int'(res_col) == g*ACC + j, "R9 column tag", int'(res_col), g*ACC + j);
        chk(int'($signed(res_data)) == ref_c(r, g*ACC + j), dtag,
            int'($signed(res_data)), ref_c(r, g*ACC + j));
        cnt++; mat_cnt++;
        if (j == ACC-1) begin j = 0; r++; end else j++;
      end else if (res_valid) begin
        held = 1'b1; hd = res_data; hc = res_col;
      end
      @(posedge clk); #1;
      if (cnt == N*ACC) chk(grp_done, "R8 pulse after last result", grp_done, 1);
      res_ready = ($urandom_range(99) < rprob);
    end
    res_ready = 1'b0;
    @(posedge clk); #1;
    chk(!grp_done, "R8 pulse one cycle", grp_done, 0);
  endtask

  task automatic run_group(input int g, input int vprob, input int rprob,
                           input bit garbage, input string dtag);
    load_group(g);
    cols_loaded = 1'b1;
    fork
      drive_x(vprob, garbage);
      sink(g, rprob, dtag);
    join
    x_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!x_ready && !res_valid, "R10 no intake before reload", x_ready, 0);
    end
    x_valid = 1'b0;
    cols_loaded = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cols_loaded = 1'b0; ld_we = 1'b0; ld_k = '0; ld_j = '0;
    ld_data = '0; x_valid = 1'b0; x_data = '0; res_ready = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!x_ready && !res_valid && !grp_done, "R1 reset outputs",
        {x_ready, res_valid, grp_done}, 0);
    x_valid = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk(!x_ready, "R3 no intake before load flag", x_ready, 0);
    end
    x_valid = 1'b0;

    // matrix A: random values, random gaps and back-pressure
    for (int i = 0; i < N; i++)
      for (int k = 0; k < N; k++) begin
        X[i][k] = int'($urandom_range(255)) - 128;
        Y[i][k] = int'($urandom_range(255)) - 128;
      end
    mat_cnt = 0;
    run_group(0, 70, 60, 1'b0, "R4 product");
    run_group(1, 70, 60, 1'b0, "R4 product");
    chk(mat_cnt == N*N, "R5 result count", mat_cnt, N*N);

    // matrix B: extreme values; stall-free group with stray writes, then heavy back-pressure
    for (int i = 0; i < N; i++)
      for (int k = 0; k < N; k++) begin
        X[i][k] = ((i + k) % 3 == 0) ? 127 : -128;
        Y[i][k] = (i == 5) ? 127 : -128;
      end
    mat_cnt = 0;
    run_group(0, 100, 100, 1'b1, "R2 writes during compute ignored");
    chk(stalls == 0, "R6 full throughput", stalls, 0);
    run_group(1, 100, 15, 1'b0, "R4 extreme product");
    chk(mat_cnt == N*N, "R5 result count", mat_cnt, N*N);

    summary();
    $finish;
  end
endmodule